// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns system-bus addresses into addresses on the wider PCIe fabric side. Six windows are set up through a small register port. Each window has three parts: a base on the system side, a length counted in 4 KiB pages, and a packed target field that holds the fabric-side page number. When an address is presented with its strobe, every window tests the address in parallel. The hit with the lowest index wins. On the next clock the block returns the fabric-side address, a hit flag and the number of the winning window.

By convention, window 0 serves configuration space, window 1 serves downstream I/O, and windows 2 and 3 serve prefetchable and non-prefetchable memory. Windows 4 and 5 are spares and are normally left at zero. The block also holds seven more registers: two upstream cache windows, each with a base and a length, plus an MSI window with a length, a fabric base and a system base. These registers are storage only and play no part in translation.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every register reads back zero, `out_valid` is low and `out_hit` is low.
- R2: The window registers are 32-bit read/write registers at byte offsets that depend on window n. The length register is at 0x00+4n, the system base at 0x18+4n and the target at 0x30+4n. A read returns the last value written.
- R3: The storage-only registers are at 0x48, 0x4C, 0x50, 0x54, 0x60, 0x64 and 0x68. A read returns the last value written.
- R4: A write to any other byte offset, including one that is not 4-byte aligned, changes no register. A read from such an offset returns zero.
- R5: Window n hits when its length L is nonzero and its base B satisfies B ≤ addr < B + L·4096. This comparison is done without wrap-around at the top of the 32-bit space.
- R6: A window whose length is zero never hits. This includes a window whose registers are all zero.
- R7: When several windows hit, `out_idx` reports the lowest-indexed one.
- R8: On a hit, `out_addr` equals (target[31:4] << 12) + (addr − B), as a 40-bit value. Target bit 0 is an enable marker that software sets, and it does not take part in the sum.
- R9: On a miss, `out_hit` is 0, and `out_idx` and `out_addr` are both 0.
- R10: `out_valid` is high exactly one cycle after `in_valid`. The result outputs change only on the edge that samples `in_valid` high; otherwise they hold.
- R11: When a register write and a lookup happen on the same edge, the lookup uses the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | System-side address to translate |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_hit | output | 1 | Some window matched |
| out_idx | output | 3 | Index of the matching window |
| out_addr | output | 40 | Fabric-side address |

## Verification
A configuration write and a lookup can arrive on the same clock edge. One such write sets a window's length to zero while that window is being looked up. The bench provokes this directly. It expects the result to still show the old hit, then sends the same address again and expects a miss. A second probe into the region where two windows overlap then shows the higher-indexed window taking over after the lower one was shut. Overlap priority and the first and last byte of each window, including a window that runs past the top of the 32-bit space, are covered by a vector table.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int DW      = 32;                    // register and system address width
  localparam int RAW     = 8;                     // register byte-offset width
  localparam int PAGE_SH = 12;                    // 4 KiB page
  localparam int TGT_LSB = 4;                     // page field starts here in target reg
  localparam int OW      = DW - TGT_LSB + PAGE_SH; // fabric address width
  localparam int SPW     = DW + PAGE_SH;          // window span width in bytes
  localparam int LEN_OFS = 'h00;
  localparam int BAS_OFS = 'h18;
  localparam int TGT_OFS = 'h30;
  localparam int NAUX    = 7;

  function automatic logic [RAW-1:0] aux_ofs(input int k);
    logic [RAW-1:0] r;
    case (k)
      0: r = RAW'('h48);
      1: r = RAW'('h4C);
      2: r = RAW'('h50);
      3: r = RAW'('h54);
      4: r = RAW'('h60);
      5: r = RAW'('h64);
      default: r = RAW'('h68);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NWIN = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [DW-1:0]  win_len [NWIN],
  output logic [DW-1:0]  win_base[NWIN],
  output logic [DW-1:0]  win_tgt [NWIN]
);
  logic [NWIN-1:0] ld_len, ld_base, ld_tgt;
  logic [NAUX-1:0] ld_aux;
  logic [DW-1:0]   aux_q [NAUX];

  // write decode (next-state side)
  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      ld_len[i]  = we && (addr == RAW'(LEN_OFS + 4*i));
      ld_base[i] = we && (addr == RAW'(BAS_OFS + 4*i));
      ld_tgt[i]  = we && (addr == RAW'(TGT_OFS + 4*i));
    end
    for (int k = 0; k < NAUX; k++)
      ld_aux[k] = we && (addr == aux_ofs(k));
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_len[i]  <= '0;
        win_base[i] <= '0;
        win_tgt[i]  <= '0;
      end else begin
        if (ld_len[i])  win_len[i]  <= wdata;
        if (ld_base[i]) win_base[i] <= wdata;
        if (ld_tgt[i])  win_tgt[i]  <= wdata;
      end
    end
  end

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         aux_q[k] <= '0;
      else if (ld_aux[k]) aux_q[k] <= wdata;
    end
  end

  // read mux: unmapped offsets give zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (addr == RAW'(LEN_OFS + 4*i)) rdata = win_len[i];
      if (addr == RAW'(BAS_OFS + 4*i)) rdata = win_base[i];
      if (addr == RAW'(TGT_OFS + 4*i)) rdata = win_tgt[i];
    end
    for (int k = 0; k < NAUX; k++)
      if (addr == aux_ofs(k)) rdata = aux_q[k];
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
(
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] len,
  input  logic [DW-1:0] tgt,
  output logic          hit,
  output logic [OW-1:0] xaddr
);
  logic [DW:0]     diff;
  logic [SPW-1:0]  span;
  logic [SPW-1:0]  ofs_w;
  logic [OW-1:0]   page_base;

  always_comb begin
    diff      = {1'b0, addr} - {1'b0, base};
    span      = {len, {PAGE_SH{1'b0}}};
    ofs_w     = SPW'(diff[DW-1:0]);
    hit       = (len != '0) && !diff[DW] && (ofs_w < span);
    page_base = {tgt[DW-1:TGT_LSB], {PAGE_SH{1'b0}}};
    xaddr     = page_base + OW'(diff[DW-1:0]);
  end
endmodule

// File: rtl/obwin_prio.sv
module obwin_prio
  import obwin_pkg::*;
#(
  parameter int NWIN = 6,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NWIN-1:0] hits,
  input  logic [OW-1:0]   xaddr [NWIN],
  output logic            any,
  output logic [IW-1:0]   idx,
  output logic [OW-1:0]   addr
);
  // scan downward so the lowest index is written last
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    addr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any  = 1'b1;
        idx  = IW'(i);
        addr = xaddr[i];
      end
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NWIN = 6,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_addr,
  output logic           out_valid,
  output logic           out_hit,
  output logic [IW-1:0]  out_idx,
  output logic [OW-1:0]  out_addr
);
  logic [DW-1:0]   len_w [NWIN];
  logic [DW-1:0]   base_w[NWIN];
  logic [DW-1:0]   tgt_w [NWIN];
  logic [NWIN-1:0] hits;
  logic [OW-1:0]   xa [NWIN];
  logic            sel_any;
  logic [IW-1:0]   sel_idx;
  logic [OW-1:0]   sel_addr;
  logic            nxt_hit;
  logic [IW-1:0]   nxt_idx;
  logic [OW-1:0]   nxt_addr;

  obwin_regs #(.NWIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .win_len(len_w), .win_base(base_w), .win_tgt(tgt_w)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_m
    obwin_match u_match (
      .addr(in_addr), .base(base_w[i]), .len(len_w[i]), .tgt(tgt_w[i]),
      .hit(hits[i]), .xaddr(xa[i])
    );

    assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (len_w[i] == '0) |-> !hits[i]);
  end

  obwin_prio #(.NWIN(NWIN)) u_prio (
    .hits(hits), .xaddr(xa), .any(sel_any), .idx(sel_idx), .addr(sel_addr)
  );

  // next-state
  always_comb begin
    nxt_hit  = sel_any;
    nxt_idx  = sel_any ? sel_idx  : '0;
    nxt_addr = sel_any ? sel_addr : '0;
  end

  // result register, loaded only with a lookup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= nxt_hit;
        out_idx  <= nxt_idx;
        out_addr <= nxt_addr;
      end
    end
  end

  assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_hit) && $stable(out_addr) && $stable(out_idx)));

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_addr == '0 && out_idx == '0));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_any |-> (hits[sel_idx] && ((hits & ((NWIN'(1) << sel_idx) - NWIN'(1))) == '0)));
endmodule

// File: tb/sim_obwin_xlate.sv
module sim_obwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        in_valid;
  logic [31:0] in_addr;
  logic        out_valid, out_hit;
  logic [2:0]  out_idx;
  logic [39:0] out_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  obwin_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_idx(out_idx), .out_addr(out_addr)
  );

  // {addr, hit, idx, translated}
  localparam int NV = 17;
  localparam logic [75:0] VEC [NV] = '{
    {32'h1000_0000, 1'b1, 3'd0, 40'h00_2000_0000},
    {32'h1000_7FFF, 1'b1, 3'd0, 40'h00_2000_7FFF},
    {32'h1000_8000, 1'b1, 3'd0, 40'h00_2000_8000},
    {32'h1000_FFFF, 1'b1, 3'd0, 40'h00_2000_FFFF},
    {32'h1001_0000, 1'b1, 3'd1, 40'hAB_CDE1_A000},
    {32'h1001_7FFF, 1'b1, 3'd1, 40'hAB_CDE2_1FFF},
    {32'h1001_8000, 1'b0, 3'd0, 40'h0},
    {32'h0FFF_FFFF, 1'b0, 3'd0, 40'h0},
    {32'h8000_0000, 1'b1, 3'd2, 40'hFF_FFFF_F000},
    {32'h8000_0FFF, 1'b1, 3'd2, 40'hFF_FFFF_FFFF},
    {32'h8000_1000, 1'b0, 3'd0, 40'h0},
    {32'h4000_0000, 1'b1, 3'd3, 40'h01_2345_6000},
    {32'h7FFF_FFFF, 1'b1, 3'd3, 40'h01_6345_5FFF},
    {32'h0000_0000, 1'b0, 3'd0, 40'h0},
    {32'hFFFF_FFFF, 1'b1, 3'd5, 40'h00_0001_0FFF},
    {32'hFFFF_F000, 1'b1, 3'd5, 40'h00_0001_0000},
    {32'h3FFF_FFFF, 1'b0, 3'd0, 40'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [31:0] wlen [6];
  logic [31:0] wbas [6];
  logic [31:0] wtgt [6];
  logic [31:0] auxv [7];
  logic [7:0]  auxo [7];

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_addr = '0;
    wlen = '{32'h10, 32'h10, 32'h1, 32'h0004_0000, 32'h0, 32'h2};
    wbas = '{32'h1000_0000, 32'h1000_8000, 32'h8000_0000, 32'h4000_0000, 32'h0, 32'hFFFF_F000};
    wtgt = '{32'h0020_0001, 32'hABCD_E121, 32'hFFFF_FFF1, 32'h0123_4561, 32'h0, 32'h0000_0101};
    auxv = '{32'hA5A5_0001, 32'h8000_0000, 32'h0000_0003, 32'h1234_5678,
             32'h0000_0010, 32'hCAFE_0000, 32'hBEEF_0000};
    auxo = '{8'h48, 8'h4C, 8'h50, 8'h54, 8'h60, 8'h64, 8'h68};
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
    chk(out_hit == 1'b0, "R1 out_hit", 64'(out_hit), 64'(0));
    rd_chk(8'h00, 32'h0, "R1 len0");
    rd_chk(8'h2C, 32'h0, "R1 base5");
    rd_chk(8'h68, 32'h0, "R1 aux");
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      wr(8'(4*i), wlen[i]);
      wr(8'(8'h18 + 4*i), wbas[i]);
      wr(8'(8'h30 + 4*i), wtgt[i]);
    end
    for (int k = 0; k < 7; k++) wr(auxo[k], auxv[k]);

    // R2 and R3: readback
    for (int i = 0; i < 6; i++) begin
      rd_chk(8'(4*i), wlen[i], "R2 len");
      rd_chk(8'(8'h18 + 4*i), wbas[i], "R2 base");
      rd_chk(8'(8'h30 + 4*i), wtgt[i], "R2 target");
    end
    for (int k = 0; k < 7; k++) rd_chk(auxo[k], auxv[k], "R3 storage");

    // R4: unmapped writes ignored
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h6C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h49, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk(8'h58, 32'h0, "R4 unmapped read");
    rd_chk(8'h6C, 32'h0, "R4 unmapped read");
    rd_chk(8'hFC, 32'h0, "R4 unmapped read");
    rd_chk(8'h49, 32'h0, "R4 unaligned read");
    rd_chk(8'h48, auxv[0], "R4 neighbour intact");
    rd_chk(8'h00, wlen[0], "R4 neighbour intact");
    for (int k = 0; k < 7; k++) rd_chk(auxo[k], auxv[k], "R4 storage intact");

    // vector table: R5 range, R7 priority, R8 translation, R9 miss
    for (int v = 0; v < NV; v++) begin
      look(VEC[v][75:44]);
      chk(out_valid == 1'b1, "R10 valid", 64'(out_valid), 64'(1));
      chk(out_hit == VEC[v][43], "R5 hit", 64'(out_hit), 64'(VEC[v][43]));
      chk(out_idx == VEC[v][42:40], "R7 index", 64'(out_idx), 64'(VEC[v][42:40]));
      chk(out_addr == VEC[v][39:0], "R8 address", 64'(out_addr), 64'(VEC[v][39:0]));
    end

    // R6: all-zero window 4 with address 0
    look(32'h0000_0000);
    chk(out_hit == 1'b0, "R6 zero window", 64'(out_hit), 64'(0));

    // R9: miss zeroes outputs after a prior hit
    look(32'h8000_0FFF);
    look(32'h2000_0000);
    chk(out_hit == 1'b0 && out_addr == '0 && out_idx == '0, "R9 miss clears",
        64'(out_addr), 64'(0));

    // R10: hold while idle
    look(32'h4000_0010);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid drops", 64'(out_valid), 64'(0));
    in_addr = 32'h1000_0000;
    @(negedge clk);
    chk(out_addr == 40'h01_2345_6010 && out_idx == 3'd3, "R10 hold",
        64'(out_addr), 64'h01_2345_6010);

    // R11: same-edge write of window 0 length and lookup
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h0;
    in_valid = 1'b1; in_addr = 32'h1000_0000;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk(out_hit == 1'b1 && out_idx == 3'd0 && out_addr == 40'h00_2000_0000,
        "R11 old values used", 64'(out_addr), 64'h00_2000_0000);
    look(32'h1000_0000);
    chk(out_hit == 1'b0, "R11 new values next", 64'(out_hit), 64'(0));
    look(32'h1000_8000);
    chk(out_idx == 3'd1 && out_addr == 40'hAB_CDE1_2000, "R7 fallback window",
        64'(out_addr), 64'hAB_CDE1_2000);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule